// File: doc/BRIEF.md
# Dual-Threshold Result Gate

This block sits after the offset-correction stage of a converter and decides, for each finished conversion result, whether that result is accepted or dropped. An accepted result is forwarded together with an accept strobe and becomes the new held result; a dropped result raises only a drop strobe and leaves the held result untouched. Downstream logic updates its result register and completion flag only on the accept strobe. A dropped result in continuous operation does not halt the converter, so conversions keep running until one passes.

The test is chosen by an enable and a 2-bit mode, against two signed 16-bit thresholds (low-side `thr_a`, high-side `thr_b`). The incoming result is sign-extended to the threshold width, and every comparison is signed. The two range modes change meaning with the threshold order: if `thr_a <= thr_b` they test outside or inside the closed window, and if `thr_a > thr_b` they test the complementary region with the opposite inclusivity.

Control is a three-state machine. IDLE holds when no result arrives. Any valid result moves the machine to PASS when it meets the test, and to DROP when it does not. From PASS or DROP the machine returns to IDLE when no result follows, and moves straight to PASS or DROP again when a result arrives on the next cycle. PASS drives the accept strobe and DROP drives the drop strobe.

Top module: `result_window_gate`

## Requirements
- R1: During and right after reset, `acc_strobe` and `drop_strobe` are low and `acc_data` is zero.
- R2: With `cmp_en` low, every valid result is accepted, whatever the mode and thresholds.
- R3: Mode code 0 accepts a result strictly less than `thr_a`.
- R4: Mode code 1 accepts a result strictly greater than `thr_a`.
- R5: Mode code 2 accepts a result below `thr_a` or above `thr_b` when `thr_a <= thr_b`. Otherwise it accepts a result strictly greater than `thr_b` and strictly less than `thr_a`.
- R6: Mode code 3 accepts a result from `thr_a` to `thr_b` inclusive when `thr_a <= thr_b`. Otherwise it accepts a result at or above `thr_a`, or at or below `thr_b`.
- R7: `in_data` is a two's-complement value whose top bit is the sign. It is sign-extended to 16 bits, and all comparisons are signed.
- R8: The decision appears exactly one cycle after `in_valid`. For each valid input exactly one of `acc_strobe` and `drop_strobe` pulses. Neither pulses in the cycle after an invalid input.
- R9: On an accept, `acc_data` equals the accepted input. On a drop, `acc_data` keeps its previous value.
- R10: Results on consecutive cycles each get their own decision, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Result present this cycle |
| in_data | input | RES_W (12) | Signed conversion result |
| cmp_en | input | 1 | Enables the threshold test |
| cmp_mode | input | 2 | Test selection, codes 0 to 3 |
| thr_a | input | 16 | Signed threshold one |
| thr_b | input | 16 | Signed threshold two |
| acc_strobe | output | 1 | Result accepted (PASS state) |
| acc_data | output | RES_W (12) | Last accepted result |
| drop_strobe | output | 1 | Result discarded (DROP state) |

## Verification
The accept strobe, the drop strobe and the held result all change at the first rising edge after a valid input, so each is due one cycle after the stimulus. The bench drives inputs on the falling edge and checks them on the following falling edge, half a period after that register update. Inputs are applied back to back, so every step checks the decision for the input driven one cycle earlier. The expected decision and the expected held result come from a reference function that follows the mode rules. Directed cases cover each threshold boundary in both threshold orders, negative values and the disabled case. Random steps mix in idle cycles.

// File: rtl/result_window_pkg.sv
package result_window_pkg;
    localparam int THR_W = 16;

    typedef enum logic [1:0] {
        CMP_BELOW = 2'd0,
        CMP_ABOVE = 2'd1,
        CMP_SPLIT = 2'd2,
        CMP_SPAN  = 2'd3
    } cmp_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_DROP = 2'd2
    } gate_state_e;
endpackage

// File: rtl/result_sext.sv
module result_sext #(
    parameter int RES_W = 12,
    parameter int OUT_W = 16
) (
    input  logic [RES_W-1:0] raw,
    output logic [OUT_W-1:0] ext
);
    generate
        if (RES_W < OUT_W) begin : g_extend
            localparam int PAD_W = OUT_W - RES_W;
            assign ext = {{PAD_W{raw[RES_W-1]}}, raw};
        end else begin : g_same
            assign ext = raw[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/window_eval.sv
module window_eval
    import result_window_pkg::*;
(
    input  logic             en,
    input  logic [1:0]       mode,
    input  logic [THR_W-1:0] value,
    input  logic [THR_W-1:0] lim_a,
    input  logic [THR_W-1:0] lim_b,
    output logic             pass
);
    logic signed [THR_W-1:0] x_s, a_s, b_s;
    logic lt_a, gt_a, lt_b, gt_b, ordered;

    assign x_s = value;
    assign a_s = lim_a;
    assign b_s = lim_b;
    assign lt_a = x_s < a_s;
    assign gt_a = x_s > a_s;
    assign lt_b = x_s < b_s;
    assign gt_b = x_s > b_s;
    assign ordered = a_s <= b_s;

    always_comb begin
        pass = 1'b1;
        if (en) begin
            unique case (cmp_mode_e'(mode))
                CMP_BELOW: pass = lt_a;
                CMP_ABOVE: pass = gt_a;
                CMP_SPLIT: pass = ordered ? (lt_a | gt_b) : (gt_b & lt_a);
                CMP_SPAN:  pass = ordered ? (!lt_a & !gt_b) : (!lt_a | !gt_b);
                default:   pass = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
    import result_window_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             pass,
    input  logic [RES_W-1:0] in_data,
    output logic             acc_strobe,
    output logic             drop_strobe,
    output logic [RES_W-1:0] acc_data
);
    gate_state_e state_q, state_d;
    logic [RES_W-1:0] data_q;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_PASS, ST_DROP: begin
                if (in_valid) state_d = pass ? ST_PASS : ST_DROP;
                else          state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                data_q <= '0;
        else if (in_valid && pass) data_q <= in_data;
    end

    always_comb begin
        acc_strobe  = 1'b0;
        drop_strobe = 1'b0;
        unique case (state_q)
            ST_PASS: acc_strobe  = 1'b1;
            ST_DROP: drop_strobe = 1'b1;
            default: ;
        endcase
    end

    assign acc_data = data_q;
endmodule

// File: rtl/result_window_gate.sv
module result_window_gate
    import result_window_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [RES_W-1:0] in_data,
    input  logic             cmp_en,
    input  logic [1:0]       cmp_mode,
    input  logic [THR_W-1:0] thr_a,
    input  logic [THR_W-1:0] thr_b,
    output logic             acc_strobe,
    output logic [RES_W-1:0] acc_data,
    output logic             drop_strobe
);
    logic [THR_W-1:0] value_ext;
    logic             pass;

    result_sext #(.RES_W(RES_W), .OUT_W(THR_W)) u_sext (
        .raw (in_data),
        .ext (value_ext)
    );

    window_eval u_eval (
        .en    (cmp_en),
        .mode  (cmp_mode),
        .value (value_ext),
        .lim_a (thr_a),
        .lim_b (thr_b),
        .pass  (pass)
    );

    gate_fsm #(.RES_W(RES_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .pass        (pass),
        .in_data     (in_data),
        .acc_strobe  (acc_strobe),
        .drop_strobe (drop_strobe),
        .acc_data    (acc_data)
    );
endmodule

// File: rtl/result_window_chk.sv
module result_window_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [RES_W-1:0] in_data,
    input logic             cmp_en,
    input logic [1:0]       cmp_mode,
    input logic [15:0]      thr_a,
    input logic [15:0]      thr_b,
    input logic             acc_strobe,
    input logic [RES_W-1:0] acc_data,
    input logic             drop_strobe
);
    logic signed [15:0] xs;
    assign xs = 16'($signed(in_data));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!acc_strobe && !drop_strobe && acc_data == '0));

    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> $countones({acc_strobe, drop_strobe}) == 1);

    assert_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!acc_strobe && !drop_strobe));

    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cmp_en) |=> acc_strobe);

    assert_below_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cmp_en && cmp_mode == 2'd0 && xs < $signed(thr_a)) |=> acc_strobe);

    assert_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cmp_en && cmp_mode == 2'd1 && xs <= $signed(thr_a)) |=> drop_strobe);

    assert_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (acc_strobe ? (acc_data == $past(in_data)) : $stable(acc_data)));
endmodule

bind result_window_gate result_window_chk #(.RES_W(RES_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cmp_en(cmp_en), .cmp_mode(cmp_mode), .thr_a(thr_a), .thr_b(thr_b),
    .acc_strobe(acc_strobe), .acc_data(acc_data), .drop_strobe(drop_strobe)
);

// File: tb/test_result_window_gate.sv
module test_result_window_gate;
    localparam int RES_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [RES_W-1:0] in_data = '0;
    logic             cmp_en = 1'b0;
    logic [1:0]       cmp_mode = 2'd0;
    logic [15:0]      thr_a = '0;
    logic [15:0]      thr_b = '0;
    logic             acc_strobe;
    logic [RES_W-1:0] acc_data;
    logic             drop_strobe;

    int errors = 0;
    int checks = 0;
    logic [RES_W-1:0] model_data = '0;

    always #5 clk = ~clk;

    result_window_gate #(.RES_W(RES_W)) i_result_window_gate (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cmp_en(cmp_en), .cmp_mode(cmp_mode), .thr_a(thr_a), .thr_b(thr_b),
        .acc_strobe(acc_strobe), .acc_data(acc_data), .drop_strobe(drop_strobe)
    );

    function automatic bit ref_pass(bit en, bit [1:0] m, int a, int b, int x);
        if (!en) return 1'b1;
        case (m)
            2'd0: return x < a;
            2'd1: return x > a;
            2'd2: return (a <= b) ? (x < a || x > b) : (x > b && x < a);
            default: return (a <= b) ? (x >= a && x <= b) : (x >= a || x <= b);
        endcase
    endfunction

    task automatic check(bit cond, string req, string what, int act, int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one input at the falling edge, check its decision one cycle later.
    task automatic apply(bit en, bit [1:0] m, int a, int b, int x, string req);
        bit exp;
        exp = ref_pass(en, m, a, b, x);
        cmp_en = en; cmp_mode = m;
        thr_a = 16'(a); thr_b = 16'(b);
        in_data = RES_W'(x); in_valid = 1'b1;
        if (exp) model_data = RES_W'(x);
        @(negedge clk);
        check(acc_strobe == exp, req, "acc_strobe", int'(acc_strobe), int'(exp));
        check(drop_strobe == !exp, "R8", "drop_strobe", int'(drop_strobe), int'(!exp));
        check(acc_data == model_data, "R9", "acc_data", int'(acc_data), int'(model_data));
    endtask

    task automatic idle(string req);
        in_valid = 1'b0;
        in_data = '1;
        @(negedge clk);
        check(!acc_strobe && !drop_strobe, req, "strobes after idle",
              int'({acc_strobe, drop_strobe}), 0);
        check(acc_data == model_data, "R9", "acc_data idle", int'(acc_data), int'(model_data));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(!acc_strobe && !drop_strobe, "R1", "strobes in reset", int'({acc_strobe, drop_strobe}), 0);
        check(acc_data == '0, "R1", "acc_data in reset", int'(acc_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle("R8");

        // R2 disabled: everything passes
        apply(1'b0, 2'd0, -2048, -2048, 2047, "R2");
        apply(1'b0, 2'd3, 100, 50, 75, "R2");
        // R3 boundaries, signed
        apply(1'b1, 2'd0, 10, 0, 9, "R3");
        apply(1'b1, 2'd0, 10, 0, 10, "R3");
        apply(1'b1, 2'd0, -5, 0, -6, "R7");
        apply(1'b1, 2'd0, -5, 0, 2000, "R7");
        // R4 boundaries
        apply(1'b1, 2'd1, 10, 0, 11, "R4");
        apply(1'b1, 2'd1, 10, 0, 10, "R4");
        apply(1'b1, 2'd1, -100, 0, -2048, "R7");
        idle("R8");
        // R5 ordered and reversed
        apply(1'b1, 2'd2, -10, 10, -11, "R5");
        apply(1'b1, 2'd2, -10, 10, -10, "R5");
        apply(1'b1, 2'd2, -10, 10, 10, "R5");
        apply(1'b1, 2'd2, -10, 10, 11, "R5");
        apply(1'b1, 2'd2, 10, -10, 0, "R5");
        apply(1'b1, 2'd2, 10, -10, 10, "R5");
        apply(1'b1, 2'd2, 10, -10, -10, "R5");
        apply(1'b1, 2'd2, 7, 7, 7, "R5");
        // R6 ordered and reversed
        apply(1'b1, 2'd3, -10, 10, -10, "R6");
        apply(1'b1, 2'd3, -10, 10, 10, "R6");
        apply(1'b1, 2'd3, -10, 10, 11, "R6");
        apply(1'b1, 2'd3, 10, -10, 10, "R6");
        apply(1'b1, 2'd3, 10, -10, -10, "R6");
        apply(1'b1, 2'd3, 10, -10, 0, "R6");
        apply(1'b1, 2'd3, 7, 7, 7, "R6");
        idle("R8");

        // R10 random back-to-back traffic with occasional idles
        for (int i = 0; i < 600; i++) begin
            int a, b, x;
            a = int'($urandom_range(0, 600)) - 300;
            b = int'($urandom_range(0, 600)) - 300;
            x = int'($urandom_range(0, 800)) - 400;
            if ($urandom_range(0, 9) == 0) idle("R8");
            else apply($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)), a, b, x, "R10");
        end
        idle("R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule